// File: doc/BRIEF.md
# Serial Keyboard Protocol Engine

This block turns a stream of host keyboard scancodes into the byte stream of a legacy serial keyboard, and answers the command bytes that the host writes to the keyboard channel. Each accepted scancode is looked up in one of two 128-entry keycode tables. The plain table is used by default. The extended table is used for the one scancode that follows a 0xE0 prefix. The release flag in bit 7 is carried onto the translated byte.

The caps-lock and num-lock keys pass through a filter. It lets only every other press and release pair reach the output, so a host that sends a full press/release cycle for each lock toggle looks like a keyboard with latching lock keys. Command bytes can do three things: produce an identification reply, produce a layout reply, or arm a mode that swallows the next command byte, which carries the LED settings.

All output bytes collect in a byte queue. The serial channel reads that queue one byte at a time, and a byte-available flag tells it when data is waiting. The keycode tables are loaded through a write port before use.

Top module: `kbd_serial_engine`

## Requirements
- R1: An accepted scancode other than 0xE0, and not dropped by the lock filter, enqueues `table[code & 0x7F] | (code & 0x80)` in the same clock edge. The plain table is used unless the extended mode is armed.
- R2: Scancode 0xE0 enqueues nothing and arms the extended mode. The next enqueued translation uses the extended table and clears the mode.
- R3: Caps lock (press 58, release 186) and num lock (press 69, release 197) each keep a 2-bit state that starts at 0. A press flips bit 0 and a release flips bit 1. A press is dropped when the new state is 2, and a release is dropped when the new state is 3.
- R4: Command 0x01 empties the queue on the edge where it is taken. On the next three edges it enqueues 0xFF, 0x04 and 0x7F.
- R5: Command 0x07 or 0x0F empties the queue. On the next two edges it enqueues 0xFE and 0x00.
- R6: Command 0x0E arms an LED mode. The next command byte, whatever its value, is consumed with no effect, and the mode is cleared. Any other command value has no effect on the queue.
- R7: The queue holds 256 bytes. A write while it holds 256 is discarded.
- R8: When the queue is empty, `rd_data` is 0 and a read changes nothing.
- R9: `byte_avail` is high exactly when the queue holds at least one byte, including after a read that leaves bytes behind.
- R10: `scan_ready` is low while a command is presented and while a reply is being enqueued. A command that empties the queue during a reply abandons the rest of that reply.
- R11: After reset the queue is empty, both lock states are 0, and the extended and LED modes are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scan_valid | input | 1 | Scancode offered |
| scan_code | input | 8 | Host scancode; bit 7 set means release |
| scan_ready | output | 1 | Scancode taken on this edge when high with scan_valid |
| cmd_valid | input | 1 | One-cycle strobe for a command byte |
| cmd_byte | input | 8 | Command byte from the host side |
| tbl_wr_en | input | 1 | Write one keycode table entry |
| tbl_wr_ext | input | 1 | 0 selects the plain table, 1 the extended table |
| tbl_wr_idx | input | 7 | Table entry index |
| tbl_wr_data | input | 8 | Keycode to store |
| rd_en | input | 1 | Pop the head byte of the queue |
| rd_data | output | 8 | Head byte of the queue, 0 when empty |
| byte_avail | output | 1 | Queue not empty |

## Verification
The checker watches several rules on every cycle:
- a presented command always blocks scancodes;
- an empty queue always shows a zero head byte;
- a flushing command always leaves the queue empty on the next edge;
- a 0xE0 prefix never changes the queue depth;
- a full queue never grows;
- any write leaves a byte available;
- an armed LED mode always clears on the next command.

The actual keycode values, the parity of the lock-key filter, the one-shot extended lookup, the order of the reply bytes and an abandoned reply show only in the bench's scenarios. There, a behavioural reference model is compared against the ports on every clock.

// File: rtl/kbd_pkg.sv
`timescale 1ns/1ps
// Shared constants, reply encoding and helpers for the keyboard protocol engine.
// Assumes 8-bit scancodes and command bytes.
package kbd_pkg;

    localparam logic [7:0] CODE_PREFIX   = 8'hE0;
    localparam logic [7:0] CMD_IDENT     = 8'h01;
    localparam logic [7:0] CMD_LED_ARM   = 8'h0E;
    localparam logic [7:0] CMD_LAYOUT_LO = 8'h07;
    localparam logic [7:0] CMD_LAYOUT_HI = 8'h0F;

    // Lock keys: press codes; the release code is the press code with bit 7 set.
    localparam int LOCK_KEYS = 2;
    localparam logic [LOCK_KEYS-1:0][7:0] LOCK_PRESS = {8'd69, 8'd58};

    typedef enum logic [1:0] {
        RPL_IDLE   = 2'd0,
        RPL_IDENT  = 2'd1,
        RPL_LAYOUT = 2'd2
    } reply_e;

    // Byte number i of a reply.
    function automatic logic [7:0] reply_byte(reply_e kind, logic [1:0] i);
        logic [7:0] b;
        b = 8'h00;
        case (kind)
            RPL_IDENT: begin
                case (i)
                    2'd0:    b = 8'hFF;
                    2'd1:    b = 8'h04;
                    default: b = 8'h7F;
                endcase
            end
            RPL_LAYOUT: b = (i == 2'd0) ? 8'hFE : 8'h00;
            default:    b = 8'h00;
        endcase
        return b;
    endfunction

    // Index of the last byte of a reply.
    function automatic logic [1:0] reply_last(reply_e kind);
        logic [1:0] n;
        case (kind)
            RPL_IDENT:  n = 2'd2;
            RPL_LAYOUT: n = 2'd1;
            default:    n = 2'd0;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/kbd_queue.sv
`timescale 1ns/1ps
// Byte FIFO with a count, flush, and a zero head when empty.
// Assumes that flush overrides a read or write in the same cycle, and that a
// write into a full queue is dropped even when a read happens in that cycle.
module kbd_queue #(
    parameter int DEPTH = 256,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic [CW-1:0] count
);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          do_wr, do_rd;

    // Qualify read and write with the occupancy and the flush.
    always_comb begin
        do_wr = wr_en && !flush && (count != CW'(DEPTH));
        do_rd = rd_en && !flush && (count != '0);
    end

    // Present the head byte, or zero when nothing is stored.
    always_comb begin
        rd_data = (count == '0) ? '0 : mem[rptr];
    end

    // Store the incoming byte; storage is not reset.
    always_ff @(posedge clk) begin
        if (do_wr) begin
            mem[wptr] <= wr_data;
        end
    end

    // Advance the pointers and the count.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_wr) begin
                wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            end
            if (do_rd) begin
                rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
            end
            if (do_wr && !do_rd) begin
                count <= count + 1'b1;
            end else if (do_rd && !do_wr) begin
                count <= count - 1'b1;
            end
        end
    end

endmodule

// File: rtl/kbd_lock_filter.sv
`timescale 1ns/1ps
// Lock-key filter: keeps a 2-bit state per lock key and drops every other
// press/release pair. Assumes accept marks a scancode being taken this cycle.
module kbd_lock_filter
    import kbd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       accept,
    input  logic [7:0] code,
    output logic       drop
);

    logic [LOCK_KEYS-1:0] drop_vec;

    for (genvar k = 0; k < LOCK_KEYS; k++) begin : g_lock
        logic [1:0] st;
        logic [1:0] nxt;
        logic       hit_p, hit_r;

        // Decode this key's press and release codes and the toggled state.
        always_comb begin
            hit_p       = (code == LOCK_PRESS[k]);
            hit_r       = (code == {1'b1, LOCK_PRESS[k][6:0]});
            nxt         = st ^ {hit_r, hit_p};
            drop_vec[k] = (hit_p && nxt == 2'b10) || (hit_r && nxt == 2'b11);
        end

        // Keep the toggle state of the key.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st <= 2'b00;
            end else if (accept && (hit_p || hit_r)) begin
                st <= nxt;
            end
        end
    end

    // Drop the scancode if any lock key asks for it.
    always_comb begin
        drop = |drop_vec;
    end

endmodule

// File: rtl/kbd_xlate.sv
`timescale 1ns/1ps
// Scancode translator: applies the prefix handling and the lock filter, then
// looks up the plain or extended keycode table and restores the release bit.
// Assumes the tables are loaded before scancodes arrive.
module kbd_xlate
    import kbd_pkg::*;
#(
    parameter int ENTRIES = 128,
    localparam int IW     = $clog2(ENTRIES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic [7:0]    code,
    input  logic          tbl_wr_en,
    input  logic          tbl_wr_ext,
    input  logic [IW-1:0] tbl_wr_idx,
    input  logic [7:0]    tbl_wr_data,
    output logic          out_valid,
    output logic [7:0]    out_byte
);

    logic            ext_q;
    logic            lock_drop;
    logic            is_prefix;
    logic [1:0][7:0] bank_out;

    kbd_lock_filter u_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .accept (accept),
        .code   (code),
        .drop   (lock_drop)
    );

    for (genvar b = 0; b < 2; b++) begin : g_bank
        logic [7:0] tbl [ENTRIES];

        // Load one entry of this bank.
        always_ff @(posedge clk) begin
            if (tbl_wr_en && (tbl_wr_ext == 1'(b))) begin
                tbl[tbl_wr_idx] <= tbl_wr_data;
            end
        end

        // Read the entry for the current scancode.
        always_comb begin
            bank_out[b] = tbl[code[IW-1:0]];
        end
    end

    // Decide on output and form the translated byte.
    always_comb begin
        is_prefix = (code == CODE_PREFIX);
        out_valid = accept && !is_prefix && !lock_drop;
        out_byte  = bank_out[ext_q] | {code[7], 7'b0};
    end

    // Arm the extended mode on the prefix; clear it when a translation is used.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_q <= 1'b0;
        end else if (accept && is_prefix) begin
            ext_q <= 1'b1;
        end else if (out_valid) begin
            ext_q <= 1'b0;
        end
    end

endmodule

// File: rtl/kbd_cmd.sv
`timescale 1ns/1ps
// Command decoder and reply sequencer. It flushes the queue for the reply
// commands, then emits the reply one byte per cycle, and it handles the
// skip-next-byte LED mode. Assumes command bytes arrive as one-cycle strobes.
module kbd_cmd
    import kbd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [7:0] cmd_byte,
    output logic       flush,
    output logic       wr_en,
    output logic [7:0] wr_data,
    output logic       busy,
    output logic       led_mode
);

    reply_e     kind_q, start;
    logic [1:0] idx_q;

    // Decode a command that starts a reply.
    always_comb begin
        start = RPL_IDLE;
        if (cmd_valid && !led_mode) begin
            if (cmd_byte == CMD_IDENT) begin
                start = RPL_IDENT;
            end else if (cmd_byte == CMD_LAYOUT_LO || cmd_byte == CMD_LAYOUT_HI) begin
                start = RPL_LAYOUT;
            end
        end
        flush = (start != RPL_IDLE);
    end

    // Drive the reply byte while a reply is active.
    always_comb begin
        busy    = (kind_q != RPL_IDLE);
        wr_en   = busy && !flush;
        wr_data = reply_byte(kind_q, idx_q);
    end

    // Track the LED mode that swallows the next command byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            led_mode <= 1'b0;
        end else if (cmd_valid) begin
            led_mode <= !led_mode && (cmd_byte == CMD_LED_ARM);
        end
    end

    // Step through the reply bytes, restarting on a new reply command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q <= RPL_IDLE;
            idx_q  <= 2'd0;
        end else if (start != RPL_IDLE) begin
            kind_q <= start;
            idx_q  <= 2'd0;
        end else if (busy) begin
            if (idx_q == reply_last(kind_q)) begin
                kind_q <= RPL_IDLE;
                idx_q  <= 2'd0;
            end else begin
                idx_q <= idx_q + 2'd1;
            end
        end
    end

endmodule

// File: rtl/kbd_serial_engine.sv
`timescale 1ns/1ps
// Top of the keyboard protocol engine. It joins the translator and the command
// sequencer into one byte queue that the serial channel drains.
// Assumes the translator and the reply sequencer never write in the same cycle;
// scan_ready gating guarantees this.
module kbd_serial_engine
    import kbd_pkg::*;
#(
    parameter int DEPTH    = 256,
    parameter int ENTRIES  = 128,
    localparam int IW      = $clog2(ENTRIES),
    localparam int CW      = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scan_valid,
    input  logic [7:0]    scan_code,
    output logic          scan_ready,
    input  logic          cmd_valid,
    input  logic [7:0]    cmd_byte,
    input  logic          tbl_wr_en,
    input  logic          tbl_wr_ext,
    input  logic [IW-1:0] tbl_wr_idx,
    input  logic [7:0]    tbl_wr_data,
    input  logic          rd_en,
    output logic [7:0]    rd_data,
    output logic          byte_avail
);

    logic          accept;
    logic          xl_valid;
    logic [7:0]    xl_byte;
    logic          c_flush, c_wr, c_busy, led_mode;
    logic [7:0]    c_data;
    logic          q_wr_en;
    logic [7:0]    q_wr_data;
    logic [CW-1:0] q_count;

    // Take scancodes only when no command or reply owns the queue.
    always_comb begin
        scan_ready = !cmd_valid && !c_busy;
        accept     = scan_valid && scan_ready;
    end

    kbd_xlate #(.ENTRIES(ENTRIES)) u_xlate (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept      (accept),
        .code        (scan_code),
        .tbl_wr_en   (tbl_wr_en),
        .tbl_wr_ext  (tbl_wr_ext),
        .tbl_wr_idx  (tbl_wr_idx),
        .tbl_wr_data (tbl_wr_data),
        .out_valid   (xl_valid),
        .out_byte    (xl_byte)
    );

    kbd_cmd u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_byte  (cmd_byte),
        .flush     (c_flush),
        .wr_en     (c_wr),
        .wr_data   (c_data),
        .busy      (c_busy),
        .led_mode  (led_mode)
    );

    // Select the writer of the queue.
    always_comb begin
        q_wr_en   = c_wr || xl_valid;
        q_wr_data = c_wr ? c_data : xl_byte;
    end

    kbd_queue #(.DEPTH(DEPTH), .DW(8)) u_queue (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (c_flush),
        .wr_en   (q_wr_en),
        .wr_data (q_wr_data),
        .rd_en   (rd_en),
        .rd_data (rd_data),
        .count   (q_count)
    );

    // Flag waiting bytes to the serial channel.
    always_comb begin
        byte_avail = (q_count != '0);
    end

endmodule

// File: rtl/kbd_serial_engine_chk.sv
`timescale 1ns/1ps
// Property checker for the keyboard protocol engine, attached by bind.
module kbd_serial_engine_chk #(
    parameter int DEPTH = 256,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          scan_valid,
    input logic [7:0]    scan_code,
    input logic          scan_ready,
    input logic          cmd_valid,
    input logic [7:0]    cmd_byte,
    input logic          rd_en,
    input logic [7:0]    rd_data,
    input logic          byte_avail,
    input logic [CW-1:0] q_count,
    input logic          q_wr_en,
    input logic          led_mode
);

    AST_CMD_BLOCKS_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !scan_ready); // R10

    AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_avail |-> rd_data == 8'h00); // R8

    AST_IDENT_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !led_mode && cmd_byte == 8'h01 |=> q_count == '0); // R4

    AST_LAYOUT_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !led_mode && (cmd_byte == 8'h07 || cmd_byte == 8'h0F) |=> q_count == '0); // R5

    AST_PREFIX_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        scan_valid && scan_ready && scan_code == 8'hE0 && !rd_en |=> q_count == $past(q_count)); // R2

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        q_count == CW'(DEPTH) && !rd_en && !cmd_valid |=> q_count == CW'(DEPTH)); // R7

    AST_WRITE_AVAIL: assert property (@(posedge clk) disable iff (!rst_n)
        q_wr_en && !cmd_valid |=> byte_avail); // R9

    AST_LED_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && led_mode |=> !led_mode); // R6

endmodule

bind kbd_serial_engine kbd_serial_engine_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scan_valid (scan_valid),
    .scan_code  (scan_code),
    .scan_ready (scan_ready),
    .cmd_valid  (cmd_valid),
    .cmd_byte   (cmd_byte),
    .rd_en      (rd_en),
    .rd_data    (rd_data),
    .byte_avail (byte_avail),
    .q_count    (q_count),
    .q_wr_en    (q_wr_en),
    .led_mode   (led_mode)
);

// File: tb/test_kbd_serial_engine.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared with the ports on every clock,
// plus scenario checks named by requirement.
module test_kbd_serial_engine;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scan_valid = 1'b0;
    logic [7:0] scan_code = 8'h00;
    logic       scan_ready;
    logic       cmd_valid = 1'b0;
    logic [7:0] cmd_byte = 8'h00;
    logic       tbl_wr_en = 1'b0;
    logic       tbl_wr_ext = 1'b0;
    logic [6:0] tbl_wr_idx = 7'd0;
    logic [7:0] tbl_wr_data = 8'h00;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       byte_avail;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    // Reference model state
    int m_q[$];
    int m_pend[$];
    int m_main[128];
    int m_ext[128];
    bit m_extm = 1'b0;
    bit m_led  = 1'b0;
    int m_caps = 0;
    int m_num  = 0;

    kbd_serial_engine i_kbd_serial_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .scan_valid  (scan_valid),
        .scan_code   (scan_code),
        .scan_ready  (scan_ready),
        .cmd_valid   (cmd_valid),
        .cmd_byte    (cmd_byte),
        .tbl_wr_en   (tbl_wr_en),
        .tbl_wr_ext  (tbl_wr_ext),
        .tbl_wr_idx  (tbl_wr_idx),
        .tbl_wr_data (tbl_wr_data),
        .rd_en       (rd_en),
        .rd_data     (rd_data),
        .byte_avail  (byte_avail)
    );

    always #2.5 clk = ~clk;

    task automatic check(string tag, int got, int exp);
        n_checks++;
        if (got != exp) begin
            n_fails++;
            $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", tag, got, exp, $time);
        end
    endtask

    // Advance the reference model by one clock edge with the current inputs.
    task automatic model_update();
        int  pre;
        bit  rdy;
        bit  fl;
        int  wb;
        int  c;
        bit  drop;
        pre  = m_q.size();
        rdy  = !cmd_valid && m_pend.size() == 0;
        fl   = 1'b0;
        wb   = -1;
        if (cmd_valid) begin
            if (m_led) m_led = 1'b0;
            else if (cmd_byte == 8'h01) begin
                fl = 1'b1; m_pend = '{8'hFF, 8'h04, 8'h7F};
            end else if (cmd_byte == 8'h0E) m_led = 1'b1;
            else if (cmd_byte == 8'h07 || cmd_byte == 8'h0F) begin
                fl = 1'b1; m_pend = '{8'hFE, 8'h00};
            end
        end
        if (!fl && m_pend.size() > 0) begin
            wb = m_pend.pop_front();
        end else if (!fl && scan_valid && rdy) begin
            c = scan_code;
            drop = 1'b0;
            if (c == 58)  begin m_caps ^= 1; drop = (m_caps == 2); end
            if (c == 69)  begin m_num  ^= 1; drop = (m_num  == 2); end
            if (c == 186) begin m_caps ^= 2; drop = (m_caps == 3); end
            if (c == 197) begin m_num  ^= 2; drop = (m_num  == 3); end
            if (c == 8'hE0) begin
                m_extm = 1'b1;
                drop = 1'b1;
            end
            if (!drop) begin
                wb = (m_extm ? m_ext[c & 127] : m_main[c & 127]) | (c & 128);
                m_extm = 1'b0;
            end
        end
        if (fl) begin
            m_q.delete();
        end else begin
            if (rd_en && pre > 0) void'(m_q.pop_front());
            if (wb >= 0 && pre < 256) m_q.push_back(wb);
        end
        if (tbl_wr_en) begin
            if (tbl_wr_ext) m_ext[tbl_wr_idx] = tbl_wr_data;
            else            m_main[tbl_wr_idx] = tbl_wr_data;
        end
    endtask

    // One clock: drive, compare with the model, update it, pass the edge.
    task automatic step(bit sv, int sc, bit cv, int cb, bit rd, string tag = "", int exp = -1);
        @(negedge clk);
        scan_valid = sv; scan_code = 8'(sc);
        cmd_valid  = cv; cmd_byte  = 8'(cb);
        rd_en      = rd;
        #1;
        check("R9 byte_avail", int'(byte_avail), int'(m_q.size() > 0));
        check("R1 rd_data", int'(rd_data), (m_q.size() > 0) ? m_q[0] : 0);
        check("R10 scan_ready", int'(scan_ready), int'(!cmd_valid && m_pend.size() == 0));
        if (exp >= 0) check(tag, int'(rd_data), exp);
        model_update();
        @(posedge clk);
        #1;
        scan_valid = 1'b0; cmd_valid = 1'b0; rd_en = 1'b0; tbl_wr_en = 1'b0;
    endtask

    task automatic scan(int sc);
        step(1'b1, sc, 1'b0, 0, 1'b0);
    endtask

    task automatic cmd(int cb);
        step(1'b0, 0, 1'b1, cb, 1'b0);
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) step(1'b0, 0, 1'b0, 0, 1'b0);
    endtask

    task automatic pop(string tag, int exp);
        step(1'b0, 0, 1'b0, 0, 1'b1, tag, exp);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 128; i++) begin
            m_main[i] = 0;
            m_ext[i]  = 0;
        end
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        // R11: reset state
        check("R11 avail after reset", int'(byte_avail), 0);
        check("R8 empty head after reset", int'(rd_data), 0);
        check("R11 ready after reset", int'(scan_ready), 1);

        // Load both tables with distinct 7-bit values.
        for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            tbl_wr_en   = 1'b1;
            tbl_wr_ext  = (i >= 128);
            tbl_wr_idx  = 7'(i);
            tbl_wr_data = (i < 128) ? 8'(((i * 7) + 3) & 127) : 8'(((i - 128) ^ 8'h55) & 127);
            step(1'b0, 0, 1'b0, 0, 1'b0);
        end

        // R1: press and release carry the release bit
        scan(8'h10);
        scan(8'h90);
        pop("R1 press", ((16 * 7) + 3) & 127);
        pop("R1 release", (((16 * 7) + 3) & 127) | 128);

        // R2: prefix is silent and applies once
        scan(8'hE0);
        check("R2 prefix silent", int'(byte_avail), 0);
        scan(8'h1C);
        scan(8'h1C);
        pop("R2 extended lookup", (8'h1C ^ 8'h55) & 127);
        pop("R2 back to plain", ((28 * 7) + 3) & 127);

        // R3: lock keys pass every other pair
        scan(58); scan(186); scan(58); scan(186);
        pop("R3 caps press", ((58 * 7) + 3) & 127);
        pop("R3 caps release", (((58 * 7) + 3) & 127) | 128);
        check("R3 caps pair dropped", int'(byte_avail), 0);
        scan(69); scan(197); scan(69); scan(197);
        pop("R3 num press", ((69 * 7) + 3) & 127);
        pop("R3 num release", (((69 * 7) + 3) & 127) | 128);
        check("R3 num pair dropped", int'(byte_avail), 0);

        // R4: identification reply replaces queued data
        scan(8'h11);
        cmd(8'h01);
        check("R4 flushed", int'(byte_avail), 0);
        idle(3);
        pop("R4 byte0", 8'hFF);
        pop("R4 byte1", 8'h04);
        pop("R4 byte2", 8'h7F);
        check("R4 reply done", int'(byte_avail), 0);

        // R6: LED byte is swallowed, unknown commands ignored
        scan(8'h11);
        cmd(8'h0E);
        cmd(8'h01);
        idle(3);
        pop("R6 led byte skipped", ((17 * 7) + 3) & 127);
        check("R6 nothing added", int'(byte_avail), 0);
        cmd(8'h55);
        idle(2);
        check("R6 unknown command ignored", int'(byte_avail), 0);

        // R5: layout replies for both command values
        cmd(8'h07);
        idle(2);
        pop("R5 layout 07 byte0", 8'hFE);
        pop("R5 layout 07 byte1", 8'h00);
        cmd(8'h0F);
        idle(2);
        pop("R5 layout 0F byte0", 8'hFE);
        pop("R5 layout 0F byte1", 8'h00);

        // R10: restart mid-reply, scancode blocked while busy
        cmd(8'h01);
        idle(1);
        cmd(8'h07);
        scan(8'h12);
        idle(2);
        pop("R10 restarted reply byte0", 8'hFE);
        pop("R10 restarted reply byte1", 8'h00);
        check("R10 blocked scancode absent", int'(byte_avail), 0);

        // R7: fill to 256, extra write dropped
        for (int i = 0; i < 256; i++) scan(8'h11);
        scan(8'h12);
        check("R9 full avail", int'(byte_avail), 1);
        for (int i = 0; i < 255; i++) pop("R7 fill data", ((17 * 7) + 3) & 127);
        pop("R7 last kept byte", ((17 * 7) + 3) & 127);
        check("R7 extra dropped", int'(byte_avail), 0);

        // R8: empty reads return 0
        pop("R8 empty read", 0);
        check("R8 still empty", int'(byte_avail), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule